// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast oscillator clock by a programmable integer N = 64·B + A and emits one single-cycle pulse per N input cycles. The pulse feeds a phase comparator. A dual-modulus prescaler divides by 64 or 65. It is built around a synchronous divide-by-4/5 core. A 6-bit swallow count A and a 9-bit main count B steer the prescaler modulus. In every output period the prescaler runs at 65 for the first A of its cycles and at 64 for the other B − A cycles. Both counts then reload.

A companion 9-bit reference divider runs in the reference clock domain. It emits one comparison pulse per R reference cycles. Ratio values come from parallel configuration inputs. Each counter samples them only at the moment it reloads, so every output period uses one complete ratio. A setting with B not above A is refused. The divider keeps its previous ratio and raises an error flag.

Top module: `pulse_swallow_div`

## Requirements
- R1: `fb_pulse` goes high once every N = 64·B + A cycles of `vco_clk`, with B taken from `cfg_b` and A from `cfg_a`.
- R2: Within an output period, the first A prescaler cycles last 65 input cycles each and the remaining B − A cycles last 64. The modulus never changes inside a prescaler cycle.
- R3: `fb_pulse` and `ref_pulse` are each high for exactly one cycle of their own clock.
- R4: A takes any value from 0 to 63, including both ends. B = A + 1 is accepted.
- R5: `cfg_a`, `cfg_b` and `cfg_r` are sampled only when the matching counter reloads. A period already running finishes at the old ratio, and the next period uses the new one.
- R6: If `cfg_b` ≤ `cfg_a` at a feedback reload, `ratio_err` becomes 1 and the previous A and B stay in use. The next reload with `cfg_b` > `cfg_a` clears `ratio_err` and adopts the new values.
- R7: `ref_pulse` goes high once every R cycles of `ref_clk`. An `cfg_r` value of 0 divides by 1, the same as a value of 1.
- R8: While a reset is low, its outputs are 0. After reset the feedback ratio is B = 64, A = 0 (N = 4096) and the reference ratio is 10, until a reload adopts new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Oscillator clock to be divided |
| vco_rst_n | input | 1 | Active-low asynchronous reset, feedback side |
| ref_clk | input | 1 | Reference clock |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference side |
| cfg_b | input | 9 | Main count B |
| cfg_a | input | 6 | Swallow count A |
| cfg_r | input | 9 | Reference ratio R |
| fb_pulse | output | 1 | One-cycle pulse per N oscillator cycles |
| ref_pulse | output | 1 | One-cycle pulse per R reference cycles |
| ratio_err | output | 1 | Last sampled B was not above A |

## Verification
The bench runs a vector table of B/A pairs and measures the gap between successive feedback pulses against 64·B + A.

- Pairs with A = 0 show whether the 64 path works on its own.
- Pairs with A = B − 1 and A = 63 show whether swallowed cycles are counted exactly once each.
- Pairs with B ≤ A, one of them B = A, check that the error flag is raised and the prior ratio is kept.

Directed sequences change the inputs right after a pulse. They check that the next gap still shows the old ratio and the one after it shows the new ratio. Reference gaps at R = 0, 1, 2 and 511 cover the divider's limits.

// File: rtl/psw_pkg.sv
package psw_pkg;

   // prescaler modulus selection
   typedef enum logic {
      MOD_LOW  = 1'b0,   // divide by 2**PRE_LOG2
      MOD_HIGH = 1'b1    // divide by 2**PRE_LOG2 + 1
   } psw_mod_e;

   // length of the 4/5 core in its short state
   localparam int PSW_CORE_LEN = 4;

endpackage

// File: rtl/psw_prescaler.sv
// Dual-modulus prescaler: a 4/5 core followed by a binary outer counter.
// The core stretches to 5 once per outer wrap when the modulus is high.
module psw_prescaler
   import psw_pkg::*;
#(
   parameter int PRE_LOG2 = 6
) (
   input  logic     clk,
   input  logic     rst_n,
   input  psw_mod_e mod_sel,
   output logic     cyc_end
);

   localparam int OUTER_W = PRE_LOG2 - 2;

   if (PRE_LOG2 < 2) begin : g_bad_log2
      $error("psw_prescaler: PRE_LOG2 must be at least 2");
   end

   logic [2:0] core_q;
   logic [2:0] core_last;
   logic       outer_last;

   assign core_last = (mod_sel == MOD_HIGH && outer_last) ?
                      3'(PSW_CORE_LEN) : 3'(PSW_CORE_LEN - 1);

   generate
      if (OUTER_W == 0) begin : g_core_only
         assign outer_last = 1'b1;
      end else begin : g_outer
         logic [OUTER_W-1:0] outer_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               outer_q <= '0;
            else if (core_q == core_last)
               outer_q <= outer_q + 1'b1;
         end
         assign outer_last = &outer_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         core_q <= '0;
      else if (core_q == core_last)
         core_q <= '0;
      else
         core_q <= core_q + 3'd1;
   end

   assign cyc_end = outer_last && (core_q == core_last);

   // R2: the core never runs past its long length
   assert_core_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      core_q <= 3'(PSW_CORE_LEN));

endmodule

// File: rtl/psw_swallow_ctl.sv
// Swallow (A) and main (B) counters that steer the prescaler modulus.
// Both counters and their latched ratio reload on the last prescaler cycle.
module psw_swallow_ctl
   import psw_pkg::*;
#(
   parameter int A_W   = 6,
   parameter int B_W   = 9,
   parameter int A_RST = 0,
   parameter int B_RST = 64
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cyc_end,
   input  logic [A_W-1:0] cfg_a,
   input  logic [B_W-1:0] cfg_b,
   output psw_mod_e       mod_sel,
   output logic           fb_pulse,
   output logic           ratio_err
);

   if (B_W < A_W) begin : g_bad_width
      $error("psw_swallow_ctl: B_W must not be narrower than A_W");
   end
   if (B_RST <= A_RST) begin : g_bad_reset
      $error("psw_swallow_ctl: reset B must exceed reset A");
   end

   logic [A_W-1:0] a_cur, a_left, a_nxt;
   logic [B_W-1:0] b_cur, b_left, b_nxt;
   logic           last_tick;
   logic           cfg_ok;

   assign last_tick = cyc_end && (b_left == B_W'(1));
   assign cfg_ok    = cfg_b > B_W'(cfg_a);
   assign a_nxt     = cfg_ok ? cfg_a : a_cur;
   assign b_nxt     = cfg_ok ? cfg_b : b_cur;
   assign mod_sel   = (a_left != '0) ? MOD_HIGH : MOD_LOW;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_cur     <= A_W'(A_RST);
         b_cur     <= B_W'(B_RST);
         a_left    <= A_W'(A_RST);
         b_left    <= B_W'(B_RST);
         fb_pulse  <= 1'b0;
         ratio_err <= 1'b0;
      end else begin
         fb_pulse <= last_tick;
         if (cyc_end) begin
            if (last_tick) begin
               a_cur     <= a_nxt;
               b_cur     <= b_nxt;
               a_left    <= a_nxt;
               b_left    <= b_nxt;
               ratio_err <= !cfg_ok;
            end else begin
               b_left <= b_left - 1'b1;
               if (a_left != '0)
                  a_left <= a_left - 1'b1;
            end
         end
      end
   end

   // R2: modulus only moves at a prescaler cycle boundary
   assert_mod_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_end |=> $stable(mod_sel));

   // R3: feedback pulse lasts one cycle
   assert_fb_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fb_pulse |=> !fb_pulse);

   // R4: swallow count stays strictly below the main count
   assert_a_below_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
      B_W'(a_left) < b_left);

   // R5: latched ratio only changes at a reload
   assert_latch_at_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !last_tick |=> ($stable(a_cur) && $stable(b_cur)));

   // R6: an illegal pair keeps the old ratio and flags it
   assert_hold_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (last_tick && !cfg_ok) |=> ($stable(a_cur) && $stable(b_cur) && ratio_err));

endmodule

// File: rtl/psw_ref_div.sv
// Reference divider: reloads from cfg_r when its count reaches one (or zero).
module psw_ref_div #(
   parameter int R_W   = 9,
   parameter int R_RST = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [R_W-1:0] cfg_r,
   output logic           ref_pulse
);

   if (R_RST < 1) begin : g_bad_reset
      $error("psw_ref_div: reset ratio must be at least 1");
   end

   logic [R_W-1:0] r_left;
   logic           r_reload;

   assign r_reload = (r_left <= R_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_left    <= R_W'(R_RST);
         ref_pulse <= 1'b0;
      end else begin
         ref_pulse <= r_reload;
         if (r_reload)
            r_left <= cfg_r;
         else
            r_left <= r_left - 1'b1;
      end
   end

   // R7: the count only rises by a reload
   assert_ref_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (r_left > $past(r_left)) |-> $past(r_reload));

   // R3: with a ratio above one, the reference pulse lasts one cycle
   assert_ref_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_pulse && !r_reload) |=> !ref_pulse);

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
   import psw_pkg::*;
#(
   parameter int PRE_LOG2 = 6,
   parameter int A_W      = 6,
   parameter int B_W      = 9,
   parameter int R_W      = 9,
   parameter int A_RST    = 0,
   parameter int B_RST    = 64,
   parameter int R_RST    = 10
) (
   input  logic           vco_clk,
   input  logic           vco_rst_n,
   input  logic           ref_clk,
   input  logic           ref_rst_n,
   input  logic [B_W-1:0] cfg_b,
   input  logic [A_W-1:0] cfg_a,
   input  logic [R_W-1:0] cfg_r,
   output logic           fb_pulse,
   output logic           ref_pulse,
   output logic           ratio_err
);

   psw_mod_e mod_sel;
   logic     cyc_end;

   psw_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
      .clk     (vco_clk),
      .rst_n   (vco_rst_n),
      .mod_sel (mod_sel),
      .cyc_end (cyc_end)
   );

   psw_swallow_ctl #(
      .A_W   (A_W),
      .B_W   (B_W),
      .A_RST (A_RST),
      .B_RST (B_RST)
   ) u_ctl (
      .clk       (vco_clk),
      .rst_n     (vco_rst_n),
      .cyc_end   (cyc_end),
      .cfg_a     (cfg_a),
      .cfg_b     (cfg_b),
      .mod_sel   (mod_sel),
      .fb_pulse  (fb_pulse),
      .ratio_err (ratio_err)
   );

   psw_ref_div #(.R_W(R_W), .R_RST(R_RST)) u_ref (
      .clk       (ref_clk),
      .rst_n     (ref_rst_n),
      .cfg_r     (cfg_r),
      .ref_pulse (ref_pulse)
   );

endmodule

// File: tb/pulse_swallow_div_test.sv
module pulse_swallow_div_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] cfg_b = 9'd64;
   logic [5:0] cfg_a = 6'd0;
   logic [8:0] cfg_r = 9'd10;
   logic       fb_pulse, ref_pulse, ratio_err;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;   // 125 MHz

   pulse_swallow_div uut (
      .vco_clk   (clk),
      .vco_rst_n (rst_n),
      .ref_clk   (clk),
      .ref_rst_n (rst_n),
      .cfg_b     (cfg_b),
      .cfg_a     (cfg_a),
      .cfg_r     (cfg_r),
      .fb_pulse  (fb_pulse),
      .ref_pulse (ref_pulse),
      .ratio_err (ratio_err)
   );

   // columns: B, A, R, expected N, expected ref gap, expected error flag
   localparam int NV = 11;
   localparam int VEC [0:NV-1][0:5] = '{
      '{  2,  1,   5,  129,   5, 0},   // B = A+1
      '{  3,  0,   1,  192,   1, 0},   // A = 0
      '{  5,  4,   9,  324,   9, 0},
      '{  1,  0,   0,   64,   1, 0},   // smallest B, R = 0
      '{  4,  4,   7,   64,   7, 1},   // B = A refused
      '{ 10,  9, 511,  649, 511, 0},   // largest R
      '{ 64, 63,   2, 4159,   2, 0},   // A = 63
      '{ 64,  0,   3, 4096,   3, 0},
      '{  0,  0,   6, 4096,   6, 1},   // B = 0 refused
      '{  7,  3,   4,  451,   4, 0},   // error clears
      '{ 33, 32,   2, 2144,   2, 0}
   };

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic fb_gap(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (fb_pulse !== 1'b1);
   endtask

   task automatic ref_gap(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (ref_pulse !== 1'b1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      int g;
      // R8: outputs low during reset
      repeat (3) @(negedge clk);
      check("R8 fb_pulse in reset", int'(fb_pulse), 0);
      check("R8 ref_pulse in reset", int'(ref_pulse), 0);
      check("R8 ratio_err in reset", int'(ratio_err), 0);
      rst_n = 1'b1;

      // R8: default ratios
      fb_gap(g);
      fb_gap(g);
      check("R8 default N", g, 4096);
      check("R8 default error flag", int'(ratio_err), 0);
      ref_gap(g);
      ref_gap(g);
      check("R8 default R", g, 10);

      // R3: pulse width one cycle
      fb_gap(g);
      @(negedge clk);
      check("R3 fb_pulse width", int'(fb_pulse), 0);
      ref_gap(g);
      @(negedge clk);
      check("R3 ref_pulse width", int'(ref_pulse), 0);

      // R1 R2 R4 R6 R7: vector table
      for (int i = 0; i < NV; i++) begin
         cfg_b = 9'(VEC[i][0]);
         cfg_a = 6'(VEC[i][1]);
         cfg_r = 9'(VEC[i][2]);
         fb_gap(g);
         fb_gap(g);
         fb_gap(g);
         check($sformatf("R1 R2 R4 N vec%0d", i), g, VEC[i][3]);
         check($sformatf("R6 error flag vec%0d", i), int'(ratio_err), VEC[i][5]);
         ref_gap(g);
         ref_gap(g);
         ref_gap(g);
         check($sformatf("R7 ref gap vec%0d", i), g, VEC[i][4]);
      end

      // R5: change right after a pulse; the running period keeps its old ratio
      cfg_b = 9'd3; cfg_a = 6'd0;
      fb_gap(g);
      fb_gap(g);
      cfg_b = 9'd2; cfg_a = 6'd1;
      fb_gap(g);
      check("R5 period in flight keeps old N", g, 192);
      fb_gap(g);
      check("R5 following period takes new N", g, 129);

      cfg_r = 9'd5;
      ref_gap(g);
      ref_gap(g);
      cfg_r = 9'd9;
      ref_gap(g);
      check("R5 reference period in flight keeps old R", g, 5);
      ref_gap(g);
      check("R5 reference takes new R", g, 9);

      // R6: a refused pair leaves the ratio in use, then a legal pair clears the flag
      cfg_b = 9'd3; cfg_a = 6'd5;
      fb_gap(g);
      fb_gap(g);
      check("R6 ratio held after refusal", g, 129);
      check("R6 error raised", int'(ratio_err), 1);
      cfg_b = 9'd6; cfg_a = 6'd2;
      fb_gap(g);
      fb_gap(g);
      check("R6 new ratio adopted", g, 386);
      check("R6 error cleared", int'(ratio_err), 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule